// File: doc/BRIEF.md
# Wired Interrupt to Message Generator

This block turns a bank of wired interrupt lines into single-beat message writes aimed at one doorbell address. That address is fixed in hardware. Each input line has two settings and one status bit. The settings are a vector word holding an event ID and a device ID, and a trigger bit that selects level or rising-edge detection. The status bit is a pending flag that software clears by writing a 1.

The lines are grouped in nodes of 128. Global pin numbers below 64 are reserved, so input line `i` is global pin `64+i`. Node `n` (starting at 1) serves global pins `64+(n-1)*128` through `64+n*128-1`.

When a pin becomes pending, the block issues one message on a valid/ready output. The message data is the pin's event ID and the device ID travels on a sideband. If several pins wait at once, a round-robin arbiter picks which one goes next.

Software reaches the block through a 32-bit register port with a write strobe. Reads are combinational from the address.

Top module: `wired_msg_gen`

## Requirements
- R1: After reset, every register reads zero and `msg_valid` is low.
- R2: The vector word of local pin `p` in node `n` is at byte address `n*0x1000 + 0x200 + p*4`. Bits [21:12] hold the event ID and bits [11:0] hold the device ID. Bits [31:22] read zero.
- R3: The trigger words of node `n` are at `n*0x1000 + (p/32)*4`, with pin `p` at bit `p%32`. A 1 selects level-high and a 0 selects rising-edge. The words read back as written.
- R4: A rising-edge pin becomes pending on a 0-to-1 transition of its synchronised input and issues one message. Holding the input high sends nothing more. After a clear, it waits for a new rising edge.
- R5: A level pin becomes pending while its input is high. If it is cleared while still high, it is pending again and sends a new message.
- R6: A message carries `msg_data` = the event ID, zero-extended. `msg_devid` carries the device ID. `msg_addr` carries the fixed doorbell address. All are taken from the vector word at the moment the pin is picked.
- R7: Once `msg_valid` is high it stays high, with data and device ID unchanged, until `msg_ready` is seen.
- R8: A pending pin sends exactly one message and no further message until its status is cleared.
- R9: The status words are at `0xA000 + (g/32)*4`, with global pin `g` at bit `g%32`. A read returns the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Among pins pending and not yet sent, the next one chosen is the first above the last pin sent, wrapping around.
- R11: Reserved global pins 0..63, nodes 0 and above the parameter, unused node offsets and non-word-aligned addresses all read zero, and writes to them change nothing.
- R12: If a clear hits a pin in the same cycle that its trigger condition fires, the pin stays pending and a new message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_in | input | NODES*128 | Wired interrupt lines, bit i is global pin 64+i |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 32 | Fixed doorbell address |
| msg_data | output | 32 | Event ID of the sent pin |
| msg_devid | output | 12 | Device ID of the sent pin |

## Verification
A status clear and a new trigger on the same pin can land in the same cycle. That collision decides whether the pin is lost or re-sent. The bench provokes it in two ways. For a rising-edge pin, it times the clear write so it is sampled on the exact clock where the synchronised edge is detected. For a level pin, it clears while the input is held high. In both cases it requires the status bit still set and one extra message with that pin's device ID. A behavioural model running beside the design judges every cycle of output and read data.

// File: rtl/wired_msg_gen.sv
module wired_msg_gen #(
  parameter int NODES = 2,
  parameter logic [31:0] DOORBELL = 32'h0804_0040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wen,
  input  logic [15:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NODES*128-1:0]  irq_in,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [31:0]           msg_addr,
  output logic [31:0]           msg_data,
  output logic [11:0]           msg_devid
);
  localparam int NPIN = NODES * 128;
  localparam int NW   = NPIN / 32;
  localparam int IW   = $clog2(NPIN);

  logic [NPIN-1:0] s1, s2, prv, typ, pend, sent;
  logic [NPIN-1:0] setc, cand, clr_m, load_m;
  logic [21:0]     vec [NPIN];
  logic [IW-1:0]   ptr, gidx;
  logic [9:0]      md;
  logic [11:0]     mdev;
  logic            mv, found, load;

  wire aligned  = reg_addr[1:0] == 2'b00;
  wire [3:0] nd = reg_addr[15:12];
  wire node_ok  = aligned && nd != 4'd0 && int'(nd) <= NODES;
  wire is_typ   = node_ok && reg_addr[11:4] == 8'h00;
  wire is_vec   = node_ok && reg_addr[11:9] == 3'b001;
  wire is_clr   = aligned && reg_addr[15:8] == 8'hA0 &&
                  int'(reg_addr[7:2]) >= 2 && int'(reg_addr[7:2]) < 2 + NW;

  int twi, cwi, vidx;
  always_comb begin
    twi  = (int'(nd) - 1) * 4 + int'(reg_addr[3:2]);
    cwi  = int'(reg_addr[7:2]) - 2;
    vidx = (int'(nd) - 1) * 128 + int'(reg_addr[8:2]);
  end

  always_comb begin
    reg_rdata = '0;
    if (is_typ)      reg_rdata = typ[twi*32 +: 32];
    else if (is_vec) reg_rdata = {10'd0, vec[vidx]};
    else if (is_clr) reg_rdata = pend[cwi*32 +: 32];
  end

  always_comb begin
    clr_m = '0;
    if (reg_wen && is_clr) clr_m[cwi*32 +: 32] = reg_wdata;
  end

  assign setc = s2 & (typ | ~prv);
  assign cand = pend & ~sent;

  int j;
  always_comb begin
    found = 1'b0;
    gidx  = ptr;
    j     = 0;
    for (int k = 0; k < NPIN; k++) begin
      j = (int'(ptr) + 1 + k) % NPIN;
      if (!found && cand[j]) begin
        found = 1'b1;
        gidx  = IW'(j);
      end
    end
  end

  assign load = found && (!mv || msg_ready);

  always_comb begin
    load_m = '0;
    if (load) load_m[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; prv <= '0;
      typ <= '0; pend <= '0; sent <= '0;
      ptr <= '0; mv <= 1'b0; md <= '0; mdev <= '0;
    end else begin
      s1   <= irq_in;
      s2   <= s1;
      prv  <= s2;
      pend <= setc | (pend & ~clr_m);
      sent <= (sent | load_m) & ~clr_m;
      if (reg_wen && is_typ) typ[twi*32 +: 32] <= reg_wdata;
      if (load) begin
        mv   <= 1'b1;
        md   <= vec[gidx][21:12];
        mdev <= vec[gidx][11:0];
        ptr  <= gidx;
      end else if (msg_ready) begin
        mv <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPIN; i++) vec[i] <= '0;
    end else if (reg_wen && is_vec) begin
      vec[vidx] <= reg_wdata[21:0];
    end
  end

  assign msg_valid = mv;
  assign msg_data  = {22'd0, md};
  assign msg_devid = mdev;
  assign msg_addr  = DOORBELL;
endmodule

module wired_msg_gen_chk #(
  parameter int NPIN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [31:0]     msg_data,
  input logic [11:0]     msg_devid,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] sent
);
  assert_out_of_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_devid)));

  assert_sent_needs_pend_R8: assert property (@(posedge clk) disable iff (rst)
    (sent & ~pend) == '0);

  assert_issue_from_pend_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(|(pend & ~sent)));
endmodule

bind wired_msg_gen wired_msg_gen_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_data(msg_data), .msg_devid(msg_devid), .pend(pend), .sent(sent)
);

// File: tb/wired_msg_gen_tb_top.sv
`timescale 1ns/100ps
module wired_msg_gen_tb_top;
  localparam int NODES = 2;
  localparam int NPIN  = NODES * 128;
  localparam int NW    = NPIN / 32;
  localparam logic [31:0] DB = 32'h0804_0040;

  logic clk = 0, rst = 1;
  logic reg_wen = 0;
  logic [15:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NPIN-1:0] irq_in = '0;
  logic msg_valid, msg_ready = 0;
  logic [31:0] msg_addr, msg_data;
  logic [11:0] msg_devid;

  wired_msg_gen #(.NODES(NODES), .DOORBELL(DB)) dut_i (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_devid(msg_devid));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural model
  logic [NPIN-1:0] ms1, ms2, mprv, mtyp, mpend, msent;
  logic [21:0] mvec [NPIN];
  bit mv; logic [9:0] md; logic [11:0] mdev; int mptr;

  function automatic logic [31:0] m_read(logic [15:0] a);
    int node, off, g, w;
    logic [31:0] r;
    r = 0; node = a >> 12; off = a & 16'hFFF;
    if (a[1:0] != 0) return 0;
    if (node >= 1 && node <= NODES) begin
      if (off < 16) begin
        w = off >> 2;
        for (int b = 0; b < 32; b++) r[b] = mtyp[(node-1)*128 + w*32 + b];
      end else if (off >= 'h200 && off < 'h400) begin
        r = {10'd0, mvec[(node-1)*128 + ((off - 'h200) >> 2)]};
      end
    end else if (a >= 16'hA000 && a < 16'hA100) begin
      for (int b = 0; b < 32; b++) begin
        g = ((a - 16'hA000) >> 2) * 32 + b;
        if (g >= 64 && g < 64 + NPIN) r[b] = mpend[g-64];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [NPIN-1:0] nclr, nset, ld;
    int node, off, c, jj, w;
    if (rst) begin
      ms1 = 0; ms2 = 0; mprv = 0; mtyp = 0; mpend = 0; msent = 0;
      for (int i = 0; i < NPIN; i++) mvec[i] = 0;
      mv = 0; md = 0; mdev = 0; mptr = 0;
    end else begin
      nclr = 0; ld = 0;
      node = reg_addr >> 12; off = reg_addr & 16'hFFF;
      if (reg_wen && reg_addr[1:0] == 0 && reg_addr >= 16'hA008 && reg_addr < 16'hA008 + NW*4) begin
        w = (reg_addr - 16'hA008) >> 2;
        for (int b = 0; b < 32; b++) nclr[w*32+b] = reg_wdata[b];
      end
      for (int i = 0; i < NPIN; i++) nset[i] = ms2[i] && (mtyp[i] || !mprv[i]);
      c = -1;
      for (int k = 0; k < NPIN; k++) begin
        jj = (mptr + 1 + k) % NPIN;
        if (c < 0 && mpend[jj] && !msent[jj]) c = jj;
      end
      if (c >= 0 && (!mv || msg_ready)) begin
        mv = 1; md = mvec[c][21:12]; mdev = mvec[c][11:0]; mptr = c; ld[c] = 1;
      end else if (msg_ready) mv = 0;
      msent = (msent | ld) & ~nclr;
      mpend = nset | (mpend & ~nclr);
      mprv = ms2; ms2 = ms1; ms1 = irq_in;
      if (reg_wen && reg_addr[1:0] == 0 && node >= 1 && node <= NODES) begin
        if (off < 16)
          for (int b = 0; b < 32; b++) mtyp[(node-1)*128 + (off>>2)*32 + b] = reg_wdata[b];
        else if (off >= 'h200 && off < 'h400)
          mvec[(node-1)*128 + ((off - 'h200) >> 2)] = reg_wdata[21:0];
      end
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      chk("R7 msg_valid", msg_valid, mv);
      if (mv) begin
        chk("R6 msg_data", msg_data, {22'd0, md});
        chk("R6 msg_devid", msg_devid, mdev);
        chk("R6 msg_addr", msg_addr, DB);
      end
      chk("R9 reg_rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // handshake log
  logic [11:0] hs_q [$];
  always @(posedge clk) if (!rst && msg_valid && msg_ready) hs_q.push_back(msg_devid);

  function automatic int cnt(logic [11:0] d);
    int n = 0;
    foreach (hs_q[i]) if (hs_q[i] == d) n++;
    return n;
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0; reg_addr = 0;
  endtask

  task automatic rd_chk(logic [15:0] a, logic [31:0] e, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(int i, logic [15:0] a);
    wr(a, ((i + 'h200) << 12) | (i + 'h100));
  endtask

  initial begin
    int mark;
    cyc(3); rst = 0; cyc(1);
    // R1
    rd_chk(16'h1200, 0, "R1 vec reset");
    rd_chk(16'h1000, 0, "R1 type reset");
    rd_chk(16'hA008, 0, "R1 status reset");
    chk("R1 valid reset", msg_valid, 0);
    // R2
    wr(16'h1200, 32'hFFFF_FFFF);
    rd_chk(16'h1200, 32'h003F_FFFF, "R2 vec fields");
    set_pin(0, 16'h1200);
    set_pin(5, 16'h1214);
    set_pin(40, 16'h12A0);
    set_pin(130, 16'h2208);
    rd_chk(16'h2208, ((130 + 'h200) << 12) | (130 + 'h100), "R2 vec node2");
    // R3
    wr(16'h1000, 32'h20);
    wr(16'h2000, 32'h4);
    wr(16'h1004, 32'h8000_0001);
    rd_chk(16'h1000, 32'h20, "R3 type word0");
    rd_chk(16'h1004, 32'h8000_0001, "R3 type word1");
    wr(16'h1004, 0);
    // R11
    wr(16'h0000, 32'hFFFF_FFFF); wr(16'h0200, 32'hFFFF_FFFF);
    wr(16'h1400, 32'hFFFF_FFFF); wr(16'h3200, 32'hFFFF_FFFF);
    wr(16'h1202, 32'h1);
    rd_chk(16'h0200, 0, "R11 node0");
    rd_chk(16'h1400, 0, "R11 gap");
    rd_chk(16'h3200, 0, "R11 node3");
    rd_chk(16'h1202, 0, "R11 unaligned");
    rd_chk(16'h1200, ((0 + 'h200) << 12) | 'h100, "R11 unaligned write ignored");
    rd_chk(16'hA000, 0, "R11 reserved pins");
    // R4 edge pin 0
    msg_ready = 1;
    @(negedge clk); irq_in[0] = 1;
    cyc(20);
    chk("R4 one message", cnt(12'h100), 1);
    rd_chk(16'hA008, 32'h1, "R9 status set");
    wr(16'hA008, 0);
    rd_chk(16'hA008, 32'h1, "R9 write0 no effect");
    wr(16'hA008, 32'h1);
    cyc(10);
    rd_chk(16'hA008, 0, "R4 edge no re-pend");
    chk("R4 no repeat", cnt(12'h100), 1);
    irq_in[0] = 0;
    // R5 / R7 level pin 5
    msg_ready = 0;
    irq_in[5] = 1;
    cyc(12);
    chk("R7 held", msg_valid, 1);
    msg_ready = 1;
    cyc(10);
    chk("R8 single message", cnt(12'h105), 1);
    wr(16'hA008, 32'h20);
    cyc(10);
    chk("R5 re-send after clear", cnt(12'h105), 2);
    irq_in[5] = 0;
    cyc(4);
    wr(16'hA008, 32'h20);
    cyc(4);
    rd_chk(16'hA008, 0, "R5 level cleared");
    // R10 round robin
    msg_ready = 0;
    mark = hs_q.size();
    irq_in[0] = 1; irq_in[40] = 1; irq_in[130] = 1;
    cyc(12);
    msg_ready = 1;
    cyc(12);
    chk("R10 count", hs_q.size() - mark, 3);
    if (hs_q.size() >= mark + 3) begin
      chk("R10 first", hs_q[mark], 12'h128);
      chk("R10 second", hs_q[mark+1], 12'h182);
      chk("R10 third", hs_q[mark+2], 12'h100);
    end
    // R12 collision, edge pin 40 (global 104: word 0xA00C bit 8)
    irq_in[40] = 0;
    cyc(6);
    mark = cnt(12'h128);
    @(negedge clk); irq_in[40] = 1;
    @(negedge clk);
    wr(16'hA00C, 32'h100);
    cyc(10);
    rd_chk(16'hA00C, 32'h100, "R12 edge stays pending");
    chk("R12 edge new message", cnt(12'h128), mark + 1);
    // R12 level pin 130 (global 194: word 0xA018 bit 2)
    mark = cnt(12'h182);
    wr(16'hA018, 32'h4);
    cyc(10);
    rd_chk(16'hA018, 32'h4, "R12 level stays pending");
    chk("R12 level new message", cnt(12'h182), mark + 1);
    // R7 under random ready
    irq_in = '0;
    cyc(4);
    wr(16'hA008, 32'hFFFF_FFFF); wr(16'hA00C, 32'hFFFF_FFFF);
    wr(16'hA018, 32'hFFFF_FFFF);
    wr(16'h2004, 32'hFFFF_FFFF);
    for (int r = 0; r < 300; r++) begin
      @(negedge clk);
      msg_ready = $urandom_range(0, 1);
      if (r % 37 == 0) irq_in[160 + (r % 8)] = ~irq_in[160 + (r % 8)];
      if (r % 53 == 0) begin reg_wen = 1; reg_addr = 16'hA01C; reg_wdata = $urandom; end
      else reg_wen = 0;
    end
    reg_wen = 0; msg_ready = 1;
    cyc(20);
    done = 1;
    summary();
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      summary();
    end
  end
endmodule